// File: doc/BRIEF.md
# Synchronous Slave FIFO Endpoint Model

This block models the peripheral side of a byte-wide synchronous slave FIFO bridge. It holds two endpoint buffers. The OUT buffer carries host-to-device data, and an external master drains it. The IN buffer carries device-to-host data, and the master fills it. The master reaches both buffers over one shared 8-bit bidirectional data bus. A 2-bit endpoint select, active-low read, write and output-enable strobes, and two registered status flags complete that bus. All of these are sampled on the rising edge of one interface clock.

A second, simpler port stands in for the host. It pushes bytes into the OUT buffer through a valid/ready handshake. It drains finished IN packets through another valid/ready handshake that marks the final byte of each packet.

Each endpoint is split into a parameterised number of fixed-size packet buffers: four buffers of 512 bytes by default. An IN packet becomes visible to the host only once it is complete. Each endpoint has its own clear command, which discards everything it holds.

Top module: `slave_fifo_ep`

## Requirements
- R1: After reset the OUT-data flag is low (nothing to read), the IN-room flag is high, `h_fill_ready` is high and `h_drain_valid` is low.
- R2: Endpoint select 2'b00 addresses the OUT buffer and 2'b10 addresses the IN buffer. Strobes given with select 2'b01 or 2'b11 change no state.
- R3: The block drives `m_data` only while `m_oe_n` is low and the select is 2'b00. It then drives the byte at the head of the OUT buffer. At all other times it leaves the bus to the master.
- R4: Each rising edge with `m_rd_n` low, select 2'b00 and the OUT buffer non-empty removes exactly one byte. Holding read low for N edges removes N bytes.
- R5: Each rising edge with `m_wr_n` low, select 2'b10 and room in the IN buffer stores the byte on `m_data`.
- R6: Reads while the OUT buffer is empty are ignored. Writes while the IN buffer has no room are ignored. Neither changes the stored contents.
- R7: An IN packet is handed to the drain port once its 512th byte has been written. A partial packet is never offered. Bytes leave in write order, and `h_drain_last` is high on the 512th byte.
- R8: The IN-room flag goes low once all four packet buffers hold committed packets. A packet buffer that is being drained still counts as held.
- R9: `h_fill_ready` is low exactly when every OUT packet buffer is occupied. A buffer frees only when all 512 of its bytes have been read.
- R10: Both flags are registered. A flag reflects buffer state one interface-clock edge after the edge that changed that state.
- R11: A pulse on `clr_out` or `clr_in` empties that endpoint, including any partial packet, and leaves the other endpoint untouched.
- R12: Bytes written through the fill port leave on the master bus in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_addr | input | 2 | Endpoint select from the master (00 = OUT, 10 = IN) |
| m_rd_n | input | 1 | Active-low read strobe |
| m_wr_n | input | 1 | Active-low write strobe |
| m_oe_n | input | 1 | Active-low output enable for the data bus |
| m_data | inout | 8 | Bidirectional data bus |
| flag_out_has_data | output | 1 | Registered; high when the OUT buffer holds data (active-low empty) |
| flag_in_has_room | output | 1 | Registered; high when the IN buffer can take data (active-low full) |
| clr_out | input | 1 | Clear command for the OUT endpoint |
| clr_in | input | 1 | Clear command for the IN endpoint |
| h_fill_valid | input | 1 | Host offers a byte for the OUT buffer |
| h_fill_ready | output | 1 | OUT buffer accepts the offered byte |
| h_fill_data | input | 8 | Byte offered for the OUT buffer |
| h_drain_valid | output | 1 | A committed IN byte is available |
| h_drain_ready | input | 1 | Host takes the presented IN byte |
| h_drain_data | output | 8 | Presented IN byte |
| h_drain_last | output | 1 | Presented byte is the last of its packet |

## Verification
The assertions assume that the master never drives `m_data` while it holds `m_oe_n` low with the OUT endpoint selected. They also assume that the clear commands and strobes change only between rising edges. The stimulus therefore enables its own bus driver only during IN writes with output-enable high. It changes every input a fixed delay after the rising edge. Under these conditions, a behavioural model made of byte queues and counters predicts each flag, handshake and bus value, and the bench compares them every clock.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // Endpoint select codes on the master bus; only two codes address storage.
  typedef enum logic [1:0] {
    EP_OUT_SEL = 2'b00,
    EP_SPARE_A = 2'b01,
    EP_IN_SEL  = 2'b10,
    EP_SPARE_B = 2'b11
  } ep_sel_e;

  function automatic logic sel_is_out(input logic [1:0] sel);
    return sel == EP_OUT_SEL;
  endfunction

  function automatic logic sel_is_in(input logic [1:0] sel);
    return sel == EP_IN_SEL;
  endfunction

endpackage

// File: rtl/sfifo_ep_mem.sv
// Byte store with one synchronous write port and one asynchronous read port.
module sfifo_ep_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/sfifo_out_ep.sv
// Host-to-device endpoint: host fills whole packet buffers, master pops bytes.
module sfifo_out_ep #(
  parameter int DW        = 8,
  parameter int PKT_BYTES = 512,
  parameter int NUM_PKTS  = 4,
  localparam int TOTAL    = PKT_BYTES * NUM_PKTS,
  localparam int AW       = $clog2(TOTAL),
  localparam int PW       = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fill_valid,
  input  logic [DW-1:0] fill_data,
  input  logic          pop_req,
  output logic          fill_ready,
  output logic          fill_done,
  output logic          pop_done,
  output logic          avail,
  output logic [DW-1:0] head,
  output logic [PW-1:0] used
);

  logic [PW-1:0] wr_ptr, rd_ptr;

  // Start of the packet buffer that a pointer sits in.
  function automatic logic [PW-1:0] slot_floor(input logic [PW-1:0] p);
    return p & ~PW'(PKT_BYTES - 1);
  endfunction

  // Bytes of storage held, counting a partly read buffer as fully held.
  function automatic logic [PW-1:0] span(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return w - slot_floor(r);
  endfunction

  assign used       = span(wr_ptr, rd_ptr);
  assign avail      = wr_ptr != rd_ptr;
  assign fill_ready = used != PW'(TOTAL);
  assign fill_done  = fill_valid && fill_ready;
  assign pop_done   = pop_req && avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (fill_done) wr_ptr <= wr_ptr + PW'(1);
      if (pop_done)  rd_ptr <= rd_ptr + PW'(1);
    end
  end

  sfifo_ep_mem #(.DW(DW), .DEPTH(TOTAL)) u_mem (
    .clk   (clk),
    .we    (fill_done && !clr),
    .waddr (wr_ptr[AW-1:0]),
    .wdata (fill_data),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (head)
  );

endmodule

// File: rtl/sfifo_in_ep.sv
// Device-to-host endpoint: master pushes bytes, packets commit at full size.
module sfifo_in_ep #(
  parameter int DW        = 8,
  parameter int PKT_BYTES = 512,
  parameter int NUM_PKTS  = 4,
  localparam int TOTAL    = PKT_BYTES * NUM_PKTS,
  localparam int AW       = $clog2(TOTAL),
  localparam int PW       = AW + 1,
  localparam int OW       = $clog2(PKT_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          drain_ready,
  output logic          room,
  output logic          push_done,
  output logic          commit_evt,
  output logic          drain_valid,
  output logic          drain_done,
  output logic [DW-1:0] drain_data,
  output logic          drain_last,
  output logic [PW-1:0] used
);

  logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr;

  function automatic logic [PW-1:0] slot_floor(input logic [PW-1:0] p);
    return p & ~PW'(PKT_BYTES - 1);
  endfunction

  function automatic logic [PW-1:0] span(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return w - slot_floor(r);
  endfunction

  function automatic logic at_pkt_end(input logic [PW-1:0] p);
    return p[OW-1:0] == OW'(PKT_BYTES - 1);
  endfunction

  assign used        = span(wr_ptr, rd_ptr);
  assign room        = used != PW'(TOTAL);
  assign push_done   = push_req && room;
  assign commit_evt  = push_done && at_pkt_end(wr_ptr);
  assign drain_valid = rd_ptr != cm_ptr;
  assign drain_done  = drain_valid && drain_ready;
  assign drain_last  = at_pkt_end(rd_ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      cm_ptr <= '0;
      rd_ptr <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      cm_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_done)  wr_ptr <= wr_ptr + PW'(1);
      if (commit_evt) cm_ptr <= wr_ptr + PW'(1);
      if (drain_done) rd_ptr <= rd_ptr + PW'(1);
    end
  end

  sfifo_ep_mem #(.DW(DW), .DEPTH(TOTAL)) u_mem (
    .clk   (clk),
    .we    (push_done && !clr),
    .waddr (wr_ptr[AW-1:0]),
    .wdata (push_data),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (drain_data)
  );

endmodule

// File: rtl/slave_fifo_ep.sv
module slave_fifo_ep #(
  parameter int PKT_BYTES = 512,
  parameter int NUM_PKTS  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] m_addr,
  input  logic       m_rd_n,
  input  logic       m_wr_n,
  input  logic       m_oe_n,
  inout  wire  [7:0] m_data,
  output logic       flag_out_has_data,
  output logic       flag_in_has_room,
  input  logic       clr_out,
  input  logic       clr_in,
  input  logic       h_fill_valid,
  output logic       h_fill_ready,
  input  logic [7:0] h_fill_data,
  output logic       h_drain_valid,
  input  logic       h_drain_ready,
  output logic [7:0] h_drain_data,
  output logic       h_drain_last
);
  import sfifo_pkg::*;

  localparam int TOTAL = PKT_BYTES * NUM_PKTS;
  localparam int PW    = $clog2(TOTAL) + 1;

  // Named internal events, observed by the bound checker.
  logic          out_pop_req, out_pop_evt, out_fill_evt, out_avail;
  logic          in_push_req, in_push_evt, in_commit_evt, in_drain_evt, in_room;
  logic          bus_drive;
  logic [7:0]    out_head;
  logic [PW-1:0] out_used, in_used;

  assign out_pop_req = !m_rd_n && sel_is_out(m_addr);
  assign in_push_req = !m_wr_n && sel_is_in(m_addr);
  assign bus_drive   = !m_oe_n && sel_is_out(m_addr);
  assign m_data      = bus_drive ? out_head : 8'hzz;

  sfifo_out_ep #(.DW(8), .PKT_BYTES(PKT_BYTES), .NUM_PKTS(NUM_PKTS)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr_out),
    .fill_valid (h_fill_valid),
    .fill_data  (h_fill_data),
    .pop_req    (out_pop_req),
    .fill_ready (h_fill_ready),
    .fill_done  (out_fill_evt),
    .pop_done   (out_pop_evt),
    .avail      (out_avail),
    .head       (out_head),
    .used       (out_used)
  );

  sfifo_in_ep #(.DW(8), .PKT_BYTES(PKT_BYTES), .NUM_PKTS(NUM_PKTS)) u_in (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr_in),
    .push_req    (in_push_req),
    .push_data   (m_data),
    .drain_ready (h_drain_ready),
    .room        (in_room),
    .push_done   (in_push_evt),
    .commit_evt  (in_commit_evt),
    .drain_valid (h_drain_valid),
    .drain_done  (in_drain_evt),
    .drain_data  (h_drain_data),
    .drain_last  (h_drain_last),
    .used        (in_used)
  );

  // Registered flags: one edge behind the pointers that feed them.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_out_has_data <= 1'b0;
      flag_in_has_room  <= 1'b1;
    end else begin
      flag_out_has_data <= out_avail;
      flag_in_has_room  <= in_room;
    end
  end

endmodule

// File: rtl/slave_fifo_ep_chk.sv
module slave_fifo_ep_chk #(
  parameter int PKT_BYTES = 512,
  parameter int NUM_PKTS  = 4,
  localparam int TOTAL    = PKT_BYTES * NUM_PKTS,
  localparam int PW       = $clog2(TOTAL) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_out,
  input logic          clr_in,
  input logic          out_avail,
  input logic [PW-1:0] out_used,
  input logic          in_room,
  input logic [PW-1:0] in_used,
  input logic          h_drain_valid,
  input logic          h_drain_last,
  input logic          flag_out_has_data,
  input logic          flag_in_has_room
);

  AST_OUT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_used <= PW'(TOTAL)); // R9

  AST_IN_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_used <= PW'(TOTAL)); // R8

  AST_OUT_FLAG_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_out_has_data) |-> $past(out_avail)); // R10

  AST_IN_FLAG_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_in_has_room) |-> $past(!in_room)); // R8

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    h_drain_last |-> h_drain_valid); // R7

  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_avail && !clr_out) |=> (out_used >= $past(out_used))); // R6

  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_room && !clr_in) |=> (in_used <= $past(in_used))); // R6

  AST_CLR_OUT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_out |=> (out_used == '0)); // R11

  AST_CLR_IN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_in |=> (in_used == '0 && !h_drain_valid)); // R11

endmodule

bind slave_fifo_ep slave_fifo_ep_chk #(.PKT_BYTES(PKT_BYTES), .NUM_PKTS(NUM_PKTS)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .clr_out           (clr_out),
  .clr_in            (clr_in),
  .out_avail         (out_avail),
  .out_used          (out_used),
  .in_room           (in_room),
  .in_used           (in_used),
  .h_drain_valid     (h_drain_valid),
  .h_drain_last      (h_drain_last),
  .flag_out_has_data (flag_out_has_data),
  .flag_in_has_room  (flag_in_has_room)
);

// File: tb/slave_fifo_ep_tb.sv
`timescale 1ns/1ps
module slave_fifo_ep_tb;
  localparam int PKT = 512;
  localparam int NPK = 4;
  localparam int TOTAL = PKT * NPK;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, m_rd_n, m_wr_n, m_oe_n, clr_out, clr_in;
  logic [1:0] m_addr;
  logic       h_fill_valid, h_drain_ready;
  logic [7:0] h_fill_data, tb_bus;
  logic       tb_bus_en;
  wire  [7:0] m_data;
  logic       flag_out_has_data, flag_in_has_room, h_fill_ready;
  logic       h_drain_valid, h_drain_last;
  logic [7:0] h_drain_data;

  assign m_data = tb_bus_en ? tb_bus : 8'hzz;

  slave_fifo_ep u_dut (
    .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_rd_n(m_rd_n), .m_wr_n(m_wr_n),
    .m_oe_n(m_oe_n), .m_data(m_data), .flag_out_has_data(flag_out_has_data),
    .flag_in_has_room(flag_in_has_room), .clr_out(clr_out), .clr_in(clr_in),
    .h_fill_valid(h_fill_valid), .h_fill_ready(h_fill_ready), .h_fill_data(h_fill_data),
    .h_drain_valid(h_drain_valid), .h_drain_ready(h_drain_ready),
    .h_drain_data(h_drain_data), .h_drain_last(h_drain_last)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int i);
    return 8'(k * 37 + i * 5 + 1);
  endfunction

  // Behavioural reference: byte queues plus per-slot progress counters.
  logic [7:0] outq[$];
  logic [7:0] inq[$];
  logic [7:0] inpart[$];
  int out_cur, in_cur;
  logic exp_flag_out, exp_flag_in;

  always @(posedge clk) begin : model
    bit o_av, f_rdy, i_room, d_val;
    if (!rst_n) begin
      outq.delete(); inq.delete(); inpart.delete();
      out_cur = 0; in_cur = 0;
      exp_flag_out <= 1'b0; exp_flag_in <= 1'b1;
    end else begin
      o_av   = outq.size() != 0;
      f_rdy  = (outq.size() + out_cur) != TOTAL;
      i_room = (inq.size() + inpart.size() + in_cur) != TOTAL;
      d_val  = inq.size() != 0;
      exp_flag_out <= o_av;
      exp_flag_in  <= i_room;
      if (clr_out) begin
        outq.delete(); out_cur = 0;
      end else begin
        if (!m_rd_n && m_addr == 2'b00 && o_av) begin
          void'(outq.pop_front()); out_cur = (out_cur + 1) % PKT;
        end
        if (h_fill_valid && f_rdy) outq.push_back(h_fill_data);
      end
      if (clr_in) begin
        inq.delete(); inpart.delete(); in_cur = 0;
      end else begin
        if (d_val && h_drain_ready) begin
          void'(inq.pop_front()); in_cur = (in_cur + 1) % PKT;
        end
        if (!m_wr_n && m_addr == 2'b10 && i_room) begin
          inpart.push_back(m_data);
          if (inpart.size() == PKT) begin
            foreach (inpart[j]) inq.push_back(inpart[j]);
            inpart.delete();
          end
        end
      end
    end
  end

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(h_fill_ready == ((outq.size() + out_cur) != TOTAL), "R9 fill_ready", h_fill_ready, int'((outq.size() + out_cur) != TOTAL));
      check(h_drain_valid == (inq.size() != 0), "R7 drain_valid", h_drain_valid, int'(inq.size() != 0));
      if (inq.size() != 0) begin
        check(h_drain_data == inq[0], "R7 drain_data", h_drain_data, inq[0]);
        check(h_drain_last == (in_cur == PKT - 1), "R7 drain_last", h_drain_last, int'(in_cur == PKT - 1));
      end
      check(flag_out_has_data == exp_flag_out, "R10 out flag", flag_out_has_data, exp_flag_out);
      check(flag_in_has_room == exp_flag_in, "R10 in flag", flag_in_has_room, exp_flag_in);
      if (!m_oe_n && m_addr == 2'b00 && outq.size() != 0)
        check(m_data == outq[0], "R3 bus head", m_data, outq[0]);
    end
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic host_fill(input int k, input int n);
    h_fill_valid = 1'b1;
    for (int i = 0; i < n; i++) begin
      h_fill_data = pat(k, i);
      while (!h_fill_ready) cyc();
      cyc();
    end
    h_fill_valid = 1'b0;
  endtask

  task automatic master_write(input int k, input int n);
    m_addr = 2'b10; m_oe_n = 1'b1; tb_bus_en = 1'b1; m_wr_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      tb_bus = pat(k, i);
      cyc();
    end
    m_wr_n = 1'b1; tb_bus_en = 1'b0; m_addr = 2'b00;
  endtask

  task automatic drain_pkt(input int k, input string req);
    h_drain_ready = 1'b1;
    for (int i = 0; i < PKT; i++) begin
      while (!h_drain_valid) cyc();
      if (i == 0 || i == PKT - 1)
        check(h_drain_data == pat(k, i), req, h_drain_data, pat(k, i));
      if (i == PKT - 1) check(h_drain_last == 1'b1, "R7 last on final byte", h_drain_last, 1);
      cyc();
    end
    h_drain_ready = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; m_addr = 2'b00; m_rd_n = 1'b1; m_wr_n = 1'b1; m_oe_n = 1'b1;
    clr_out = 1'b0; clr_in = 1'b0; h_fill_valid = 1'b0; h_fill_data = '0;
    h_drain_ready = 1'b0; tb_bus = '0; tb_bus_en = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    #1;
    check(flag_out_has_data == 1'b0, "R1 out flag", flag_out_has_data, 0);
    check(flag_in_has_room == 1'b1, "R1 in flag", flag_in_has_room, 1);
    check(h_fill_ready == 1'b1, "R1 fill_ready", h_fill_ready, 1);
    check(h_drain_valid == 1'b0, "R1 drain_valid", h_drain_valid, 0);

    // R10: one fill, flag lags by one edge
    h_fill_valid = 1'b1; h_fill_data = pat(1, 0);
    cyc();
    h_fill_valid = 1'b0; #1;
    check(flag_out_has_data == 1'b0, "R10 flag not yet set", flag_out_has_data, 0);
    cyc(); #1;
    check(flag_out_has_data == 1'b1, "R10 flag set next edge", flag_out_has_data, 1);
    h_fill_valid = 1'b1;
    for (int i = 1; i < 6; i++) begin h_fill_data = pat(1, i); cyc(); end
    h_fill_valid = 1'b0;

    // R3 / R4: head on bus, read held two edges pops two bytes
    m_oe_n = 1'b0; #1;
    check(m_data == pat(1, 0), "R3 head driven", m_data, pat(1, 0));
    m_rd_n = 1'b0; cyc(2); m_rd_n = 1'b1; #1;
    check(m_data == pat(1, 2), "R4 two pops", m_data, pat(1, 2));

    // R2: strobes on unused selects change nothing
    m_addr = 2'b01; m_rd_n = 1'b0; cyc(2);
    m_addr = 2'b11; cyc(2);
    m_rd_n = 1'b1; m_addr = 2'b00; #1;
    check(m_data == pat(1, 2), "R2 unused select ignored", m_data, pat(1, 2));

    // R12: order preserved
    m_rd_n = 1'b0; cyc(3); m_rd_n = 1'b1; #1;
    check(m_data == pat(1, 5), "R12 fill order", m_data, pat(1, 5));

    // R6: reads past empty are ignored
    m_rd_n = 1'b0; cyc(4); m_rd_n = 1'b1;
    h_fill_valid = 1'b1; h_fill_data = pat(2, 0); cyc(); h_fill_valid = 1'b0;
    cyc(2); #1;
    check(m_data == pat(2, 0), "R6 empty read ignored", m_data, pat(2, 0));

    // R11: clear OUT
    host_fill(2, 3);
    cyc(2);
    clr_out = 1'b1; cyc(); clr_out = 1'b0; cyc(); #1;
    check(flag_out_has_data == 1'b0, "R11 out cleared", flag_out_has_data, 0);
    check(h_fill_ready == 1'b1, "R11 fill ready after clear", h_fill_ready, 1);

    // R9: full OUT, a buffer frees only after all its bytes are read
    host_fill(3, TOTAL); #1;
    check(h_fill_ready == 1'b0, "R9 full", h_fill_ready, 0);
    m_rd_n = 1'b0; cyc(); m_rd_n = 1'b1; #1;
    check(h_fill_ready == 1'b0, "R9 partly read buffer still held", h_fill_ready, 0);
    m_rd_n = 1'b0; cyc(PKT - 1); m_rd_n = 1'b1; #1;
    check(h_fill_ready == 1'b1, "R9 buffer freed", h_fill_ready, 1);
    check(m_data == pat(3, PKT), "R12 next buffer head", m_data, pat(3, PKT));
    m_oe_n = 1'b1;
    clr_out = 1'b1; cyc(); clr_out = 1'b0;

    // R5 / R7: partial packet hidden, commit on 512th byte
    master_write(4, PKT - 1); #1;
    check(h_drain_valid == 1'b0, "R7 partial hidden", h_drain_valid, 0);
    m_addr = 2'b10; tb_bus_en = 1'b1; m_wr_n = 1'b0; tb_bus = pat(4, PKT - 1);
    cyc(); m_wr_n = 1'b1; tb_bus_en = 1'b0; m_addr = 2'b00; #1;
    check(h_drain_valid == 1'b1, "R7 committed", h_drain_valid, 1);
    drain_pkt(4, "R5 written byte drained");

    // R8: four packets fill the IN side; extra writes dropped (R6)
    for (int k = 0; k < NPK; k++) master_write(5 + k, PKT);
    #1;
    check(flag_in_has_room == 1'b1, "R10 in flag lags", flag_in_has_room, 1);
    cyc(); #1;
    check(flag_in_has_room == 1'b0, "R8 full", flag_in_has_room, 0);
    master_write(20, 3);
    for (int k = 0; k < NPK; k++) drain_pkt(5 + k, "R8 stored packet");
    cyc(); #1;
    check(h_drain_valid == 1'b0, "R6 full writes dropped", h_drain_valid, 0);
    check(flag_in_has_room == 1'b1, "R8 room again", flag_in_has_room, 1);

    // R11: clear IN discards partial packet
    master_write(9, 100);
    clr_in = 1'b1; cyc(); clr_in = 1'b0;
    master_write(10, PKT);
    drain_pkt(10, "R11 partial discarded");

    cyc(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule